// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers up to eight interrupt sources on a single card and arbitrates them with a fixed-priority encoder. Lower input index means higher priority. While any unmasked request is pending, it pulls a shared active-low request line toward the processor. When the processor acknowledges, the block takes the winning index and looks up an 8-bit vector for it. It then drives a byte onto the data bus, but only for as long as the acknowledge is held low.

The block supports two acknowledge styles, chosen by the `mode_two` input. In single-byte style, the vector stays on the bus for the whole acknowledge. In two-byte style, the acknowledge is held across two memory read strobes, and memory cards keep their drivers off during this time. On the first strobe the block drives the page byte, which is the high half of the service address. On the second strobe it drives the vector, which is the low half.

The page register and a per-input mask register are written as I/O ports. Each is selected by an I/O request together with a write strobe at its own port address. Inputs, strobes and outputs are all sampled or updated on `clk`.

Top module: `prio_vec_irq`

## Requirements
- R1: Among unmasked pending inputs, the lowest index wins. Its vector is VEC_BASE + VEC_STEP*index, giving 0x40 + 2*index at the defaults.
- R2: A one-cycle high pulse on `irq_in[i]` makes input i pending at the next clock edge. `intrq_n` is low exactly while at least one pending input is unmasked.
- R3: In single-byte mode, `data_oe` is high and `data_out` carries the vector from the cycle after `intak_n` falls until `intak_n` rises. At all other times `data_oe` is 0 and `data_out` is 0x00.
- R4: The winner is captured at the clock edge that first sees `intak_n` low. It is held until the acknowledge ends, even if a higher-priority request arrives in the meantime.
- R5: An acknowledge clears only the winner's pending bit. `intrq_n` stays low if other unmasked inputs remain pending.
- R6: A cycle with `iorq_n`=0, `wr_n`=0 and `addr`=PAGE_PORT (default 0x30) loads `data_in` into the page register. A write to any other address leaves the page register unchanged.
- R7: In two-byte mode, the block drives only while `rd_n` is low inside an acknowledge. The first strobe returns the page byte and the second returns the vector. Any further strobe returns nothing.
- R8: The read-strobe counter returns to zero when `intak_n` goes high, so the next acknowledge begins again with the page byte.
- R9: A cycle with `iorq_n`=0, `wr_n`=0 and `addr`=MASK_PORT (default 0x31) loads the mask register. Mask bit i=1 keeps input i pending, but it neither drives `intrq_n` nor wins arbitration. Clearing the mask bit brings back `intrq_n`.
- R10: An acknowledge that arrives with no unmasked request pending drives nothing and leaves all pending bits as they were.
- R11: After reset, `intrq_n` is 1, `data_oe` is 0, `data_out` is 0x00, nothing is pending or masked, and the page register holds PAGE_RST (0x00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_in | input | N_SRC | Request pulses, one per source |
| addr | input | 8 | Low byte of the I/O address |
| iorq_n | input | 1 | I/O request, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| data_in | input | 8 | Write data from the bus |
| intak_n | input | 1 | Interrupt acknowledge, active low |
| mode_two | input | 1 | 1 selects the two-byte acknowledge style |
| data_out | output | 8 | Byte driven toward the data bus |
| data_oe | output | 1 | High while `data_out` must drive the bus |
| intrq_n | output | 1 | Shared interrupt request, active low |

## Verification
The bench builds the block with its defaults: eight sources, vectors 0x40 + 2*index, page port 0x30 and mask port 0x31. With these values every source can be checked against a distinct, easily recognised vector. Input 0 and input 7 are both used, which covers both ends of the priority range. The page value that the bench writes (0x12) is distinct from every vector, so a swap of the high and low bytes in two-byte mode shows up directly.

// File: rtl/prio_vec_irq.sv
module prio_vec_irq #(
  parameter int       N_SRC     = 8,
  parameter logic [7:0] PAGE_PORT = 8'h30,
  parameter logic [7:0] MASK_PORT = 8'h31,
  parameter logic [7:0] VEC_BASE  = 8'h40,
  parameter logic [7:0] VEC_STEP  = 8'h02,
  parameter logic [7:0] PAGE_RST  = 8'h00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_in,
  input  logic [7:0]       addr,
  input  logic             iorq_n,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic [7:0]       data_in,
  input  logic             intak_n,
  input  logic             mode_two,
  output logic [7:0]       data_out,
  output logic             data_oe,
  output logic             intrq_n
);
  localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [N_SRC-1:0] pend, mask, live, clr;
  logic [7:0]       page;
  logic [7:0]       vtab [N_SRC];
  logic             intak_q, rd_q, ack_act, win_vld, sel_any;
  logic [IW-1:0]    win_idx, sel_idx;
  logic [1:0]       bcnt;

  for (genvar g = 0; g < N_SRC; g++) begin : g_vtab
    assign vtab[g] = VEC_BASE + VEC_STEP * 8'(g);
  end

  assign live    = pend & ~mask;
  assign intrq_n = ~|live;

  always_comb begin
    sel_any = 1'b0;
    sel_idx = '0;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (live[i]) begin
        sel_any = 1'b1;
        sel_idx = IW'(i);
      end
  end

  wire ack_start = !intak_n && intak_q;
  wire io_wr     = !iorq_n && !wr_n;
  wire page_wr   = io_wr && (addr == PAGE_PORT);
  wire mask_wr   = io_wr && (addr == MASK_PORT);
  wire rd_end    = !rd_q && rd_n;

  assign clr = (ack_start && sel_any) ? (N_SRC'(1) << sel_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= '0;
      mask    <= '0;
      page    <= PAGE_RST;
      intak_q <= 1'b1;
      rd_q    <= 1'b1;
      ack_act <= 1'b0;
      win_vld <= 1'b0;
      win_idx <= '0;
      bcnt    <= '0;
    end else begin
      pend    <= (pend & ~clr) | irq_in;
      intak_q <= intak_n;
      rd_q    <= rd_n;
      if (page_wr) page <= data_in;
      if (mask_wr) mask <= data_in[N_SRC-1:0];
      if (intak_n)        ack_act <= 1'b0;
      else if (ack_start) ack_act <= 1'b1;
      if (ack_start) begin
        win_vld <= sel_any;
        win_idx <= sel_idx;
      end
      if (intak_n) bcnt <= '0;
      else if (ack_act && rd_end && bcnt != 2'd2) bcnt <= bcnt + 2'd1;
    end
  end

  wire drive = ack_act && win_vld && !intak_n &&
               (mode_two ? (!rd_n && bcnt != 2'd2) : 1'b1);
  wire [7:0] sel_byte = (mode_two && bcnt == 2'd0) ? page : vtab[win_idx];

  assign data_oe  = drive;
  assign data_out = drive ? sel_byte : 8'h00;

  a_r2_req_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (|(irq_in & ~mask) && !mask_wr) |=> !intrq_n);
  a_r4_winner_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_act && $past(ack_act)) |-> $stable(win_idx));
  a_r5_winner_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_start && sel_any && !irq_in[sel_idx]) |=> !pend[$past(sel_idx)]);
  a_r7_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt <= 2'd2);
  a_r8_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    intak_n |=> bcnt == 2'd0);
  a_r10_no_spurious_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_act && !win_vld) |-> !data_oe);
endmodule

// File: tb/test_prio_vec_irq.sv
module test_prio_vec_irq;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [7:0] irq_in = '0, addr = '0, data_in = '0;
  logic       iorq_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, intak_n = 1'b1, mode_two = 1'b0;
  logic [7:0] data_out;
  logic       data_oe, intrq_n;

  prio_vec_irq i_prio_vec_irq (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .addr(addr), .iorq_n(iorq_n),
    .wr_n(wr_n), .rd_n(rd_n), .data_in(data_in), .intak_n(intak_n),
    .mode_two(mode_two), .data_out(data_out), .data_oe(data_oe), .intrq_n(intrq_n));

  always #2 clk = ~clk;

  int n_chk = 0, n_err = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       prev_oe = 1'b0;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic push(input string tag, input logic [7:0] v);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  always begin
    @(negedge clk);
    #1;
    if (data_oe && !prev_oe) begin
      if (exp_q.size() == 0) check("R3 unexpected drive", data_out, 8'hxx);
      else check(tag_q.pop_front(), data_out, exp_q.pop_front());
    end
    prev_oe = data_oe;
  end

  task automatic pulse(input logic [7:0] v);
    @(negedge clk); irq_in = v;
    @(negedge clk); irq_in = '0;
  endtask

  task automatic io_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; data_in = d; iorq_n = 0; wr_n = 0;
    @(negedge clk); iorq_n = 1; wr_n = 1;
  endtask

  task automatic ack_single(input string tag, input logic [7:0] v);
    push(tag, v);
    @(negedge clk); intak_n = 0;
    repeat (3) @(negedge clk);
    #1 check("R3 oe during ack", {7'd0, data_oe}, 8'd1);
    @(negedge clk); intak_n = 1;
    #1 check("R3 oe after ack", {7'd0, data_oe}, 8'd0);
    check("R3 data idle", data_out, 8'h00);
  endtask

  task automatic read_strobe();
    @(negedge clk); rd_n = 0;
    @(negedge clk); rd_n = 1;
  endtask

  initial begin
    #400000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check("R11 intrq_n", {7'd0, intrq_n}, 8'd1);
    check("R11 oe", {7'd0, data_oe}, 8'd0);
    check("R11 data", data_out, 8'h00);
    rst_n = 1;

    // R7 / R11: two-byte with reset page
    mode_two = 1;
    pulse(8'h80);
    @(negedge clk); intak_n = 0;
    @(negedge clk);
    #1 check("R7 no drive before read", {7'd0, data_oe}, 8'd0);
    push("R11 page reset high byte", 8'h00);
    read_strobe();
    push("R7 low byte", 8'h4E);
    read_strobe();
    read_strobe();
    @(negedge clk); intak_n = 1;
    mode_two = 0;

    // R6 page write, R2/R1/R5 priority
    io_write(8'h30, 8'h12);
    pulse(8'h24);
    #1 check("R2 intrq asserted", {7'd0, intrq_n}, 8'd0);
    ack_single("R1 index 2 wins", 8'h44);
    check("R5 others keep intrq", {7'd0, intrq_n}, 8'd0);
    ack_single("R1 index 5 next", 8'h4A);
    @(negedge clk);
    #1 check("R5 all cleared", {7'd0, intrq_n}, 8'd1);

    // R4 winner held
    pulse(8'h10);
    push("R4 latched vector", 8'h48);
    @(negedge clk); intak_n = 0;
    @(negedge clk);
    pulse(8'h01);
    #1 check("R4 held during ack", data_out, 8'h48);
    @(negedge clk); intak_n = 1;
    #1 check("R4 new request pending", {7'd0, intrq_n}, 8'd0);
    ack_single("R1 index 0", 8'h40);

    // R9 mask, R10 spurious ack
    io_write(8'h31, 8'h01);
    pulse(8'h01);
    @(negedge clk);
    #1 check("R9 masked no intrq", {7'd0, intrq_n}, 8'd1);
    @(negedge clk); intak_n = 0;
    repeat (2) @(negedge clk);
    #1 check("R10 no drive", {7'd0, data_oe}, 8'd0);
    @(negedge clk); intak_n = 1;
    io_write(8'h31, 8'h00);
    @(negedge clk);
    #1 check("R9 unmask raises intrq", {7'd0, intrq_n}, 8'd0);
    ack_single("R9 masked input still pending", 8'h40);

    // R6 wrong address ignored, R8 counter restart
    io_write(8'h32, 8'h99);
    mode_two = 1;
    pulse(8'h08);
    @(negedge clk); intak_n = 0;
    push("R6 page kept", 8'h12);
    read_strobe();
    @(negedge clk); intak_n = 1;
    pulse(8'h40);
    @(negedge clk); intak_n = 0;
    @(negedge clk);
    push("R8 restart high byte", 8'h12);
    read_strobe();
    push("R7 low byte index 6", 8'h4C);
    read_strobe();
    @(negedge clk); intak_n = 1;
    repeat (3) @(negedge clk);
    check("R3 all expected drives seen", 8'(exp_q.size()), 8'd0);
    check("R5 idle intrq", {7'd0, intrq_n}, 8'd1);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule